// File: doc/BRIEF.md
# SD Host Transfer Status Tracker

This block keeps the data-transfer status of an SD/MMC host controller during transfers that software moves word by word, without DMA. It holds three read-only flags. The first says the data buffer can take the next write block. The second says a read transfer is under way. The third says a write transfer is under way. It also raises single-cycle interrupt pulses when those flags change: buffer write ready, transfer complete and block gap event.

Its inputs are event strobes from the neighbouring paths. The command path reports the end bit of a read or write command. The read path reports each block handed to the system. The host side reports a block fully written into the buffer. The card-side shifter reports a block taken out of the buffer. The CRC path reports a CRC status received for a write block. A level request asks the transfer to halt at the next block boundary. A continue strobe restarts a halted transfer. The programmed block count sets how many blocks a transfer carries.

A block counter per direction runs across halts and restarts, so a transfer that was stopped and continued ends after exactly the programmed number of blocks. The command sequencer, the SD bus shifter, CRC computation, DMA and register decoding are outside this block.

Top module: `sd_xfer_status`

## Requirements
- R1: After reset, bufWrRdy, rdActive and wrActive are 0 and all three interrupt outputs are 0.
- R2: rdActive is 1 in the cycle after a rdCmdEnd strobe. A contReq strobe sets it again when a read was halted at a block gap.
- R3: Each rdBlkToSys strobe while rdActive is 1 counts one delivered block, and the count persists across halts. The strobe that brings the count to blkCountCfg clears rdActive, whatever stopAtGap is.
- R4: When a rdBlkToSys strobe arrives that is not the last block and stopAtGap is 1, rdActive clears and the read is marked halted.
- R5: irqXferDone is 1 for exactly the first cycle in which rdActive is 0 after being 1, and is 0 otherwise.
- R6: wrActive is 1 in the cycle after a wrCmdEnd strobe. A contReq strobe sets it again when a write was halted at a block gap.
- R7: Each crcStatusRx strobe while wrActive is 1 counts one finished write block. The strobe that brings the count to blkCountCfg clears wrActive.
- R8: A crcStatusRx strobe that is not the last block and arrives with stopAtGap at 1 clears wrActive and halts the write. irqBlkGap then pulses for one cycle, in the first cycle wrActive is 0. A write that ends on its last block gives no irqBlkGap.
- R9: bufWrRdy becomes 1 in the cycle after a wrCmdEnd strobe. irqBufWrRdy is 1 for exactly the first cycle of every rise of bufWrRdy.
- R10: A wrBufFull strobe while bufWrRdy is 1 clears bufWrRdy and counts one loaded block. A wrBlkTaken strobe during an active write sets bufWrRdy again only if fewer than blkCountCfg blocks have been loaded and stopAtGap is 0.
- R11: A contReq strobe when neither direction is halted changes no flag and raises no interrupt. A contReq after a write halt sets bufWrRdy if blocks remain to be loaded.
- R12: rdBlkToSys and crcStatusRx strobes while the matching flag is 0 are not counted. A later transfer of N blocks still ends after exactly N strobes. blkCountCfg must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blkCountCfg | input | CNT_W | Programmed number of blocks per transfer (at least 1) |
| rdCmdEnd | input | 1 | End bit of a read command seen |
| wrCmdEnd | input | 1 | End bit of a write command seen |
| rdBlkToSys | input | 1 | One read block delivered to the system |
| wrBufFull | input | 1 | Host finished writing a block into the buffer |
| wrBlkTaken | input | 1 | Shifter took a block out of the buffer |
| crcStatusRx | input | 1 | CRC status of a write block received |
| stopAtGap | input | 1 | Request to halt at the next block boundary (level) |
| contReq | input | 1 | Restart a transfer halted at a gap (strobe) |
| bufWrRdy | output | 1 | Buffer can accept the next write block |
| rdActive | output | 1 | Read transfer active |
| wrActive | output | 1 | Write transfer active |
| irqBufWrRdy | output | 1 | Pulse on rise of bufWrRdy |
| irqXferDone | output | 1 | Pulse on fall of rdActive |
| irqBlkGap | output | 1 | Pulse when a write halts at a gap |

## Verification
Some properties are checked on every cycle. Each interrupt pulse lasts one cycle and agrees with the level of its flag. Every rise of an active flag follows a command end or a continue. Every fall follows a block or CRC strobe. A buffer-full strobe always drops the ready flag. Block counting across halts cannot be seen by any single-cycle property. Only the bench's scenarios show it: transfers of random length with random halts, stray strobes while idle, and continue requests with nothing halted. The same holds for the rule that a last block overrides a halt request.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;

  // Decoded actions from control to datapath
  typedef struct packed {
    logic rdStart;
    logic rdResume;
    logic rdCount;
    logic rdEnd;
    logic rdGap;
    logic wrStart;
    logic wrResume;
    logic wrCount;
    logic wrEnd;
    logic wrGap;
    logic bufSet;
    logic bufClr;
  } xfer_strobe_t;

  // State summary from datapath back to control
  typedef struct packed {
    logic rdActive;
    logic wrActive;
    logic rdStopped;
    logic wrStopped;
    logic rdLast;
    logic wrLast;
    logic loadLeft;
    logic bufWrRdy;
  } xfer_state_t;

endpackage

// File: rtl/sd_xfer_ctrl.sv
module sd_xfer_ctrl
  import sd_xfer_pkg::*;
(
  input  logic         rdCmdEnd,
  input  logic         wrCmdEnd,
  input  logic         rdBlkToSys,
  input  logic         wrBufFull,
  input  logic         wrBlkTaken,
  input  logic         crcStatusRx,
  input  logic         stopAtGap,
  input  logic         contReq,
  input  xfer_state_t  st,
  output xfer_strobe_t stb
);

  always_comb begin
    stb = '0;
    // read direction
    stb.rdStart  = rdCmdEnd;
    stb.rdResume = contReq & st.rdStopped;
    stb.rdCount  = rdBlkToSys & st.rdActive;
    stb.rdEnd    = stb.rdCount & st.rdLast;
    stb.rdGap    = stb.rdCount & ~st.rdLast & stopAtGap;
    // write direction
    stb.wrStart  = wrCmdEnd;
    stb.wrResume = contReq & st.wrStopped;
    stb.wrCount  = crcStatusRx & st.wrActive;
    stb.wrEnd    = stb.wrCount & st.wrLast;
    stb.wrGap    = stb.wrCount & ~st.wrLast & stopAtGap;
    // buffer space: gap request sampled at the block boundary only
    stb.bufClr   = wrBufFull & st.bufWrRdy;
    stb.bufSet   = stb.wrStart
                 | (stb.wrResume & st.loadLeft)
                 | (wrBlkTaken & st.wrActive & st.loadLeft & ~stopAtGap);
  end

endmodule

// File: rtl/sd_xfer_dp.sv
module sd_xfer_dp
  import sd_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] blkCountCfg,
  input  xfer_strobe_t     stb,
  output xfer_state_t      st,
  output logic             bufWrRdy,
  output logic             rdActive,
  output logic             wrActive,
  output logic             irqBufWrRdy,
  output logic             irqXferDone,
  output logic             irqBlkGap
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rdDone, wrDone, wrLoaded;
  logic             rdStopped, wrStopped;
  logic             rdPrev, wrPrev, bufPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive  <= 1'b0;
      rdStopped <= 1'b0;
      rdDone    <= '0;
    end else begin
      if (stb.rdStart || stb.rdResume) rdActive <= 1'b1;
      else if (stb.rdEnd || stb.rdGap) rdActive <= 1'b0;
      if (stb.rdStart || stb.rdResume) rdStopped <= 1'b0;
      else if (stb.rdGap)              rdStopped <= 1'b1;
      if (stb.rdStart)      rdDone <= '0;
      else if (stb.rdCount) rdDone <= rdDone + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrActive  <= 1'b0;
      wrStopped <= 1'b0;
      wrDone    <= '0;
      wrLoaded  <= '0;
      bufWrRdy  <= 1'b0;
    end else begin
      if (stb.wrStart || stb.wrResume) wrActive <= 1'b1;
      else if (stb.wrEnd || stb.wrGap) wrActive <= 1'b0;
      if (stb.wrStart || stb.wrResume) wrStopped <= 1'b0;
      else if (stb.wrGap)              wrStopped <= 1'b1;
      if (stb.wrStart)      wrDone <= '0;
      else if (stb.wrCount) wrDone <= wrDone + ONE;
      if (stb.wrStart)     wrLoaded <= '0;
      else if (stb.bufClr) wrLoaded <= wrLoaded + ONE;
      if (stb.bufClr)      bufWrRdy <= 1'b0;
      else if (stb.bufSet) bufWrRdy <= 1'b1;
    end
  end

  // previous-cycle copies for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev  <= 1'b0;
      wrPrev  <= 1'b0;
      bufPrev <= 1'b0;
    end else begin
      rdPrev  <= rdActive;
      wrPrev  <= wrActive;
      bufPrev <= bufWrRdy;
    end
  end

  assign irqBufWrRdy = bufWrRdy & ~bufPrev;
  assign irqXferDone = rdPrev & ~rdActive;
  assign irqBlkGap   = wrPrev & ~wrActive & wrStopped;

  always_comb begin
    st           = '0;
    st.rdActive  = rdActive;
    st.wrActive  = wrActive;
    st.rdStopped = rdStopped;
    st.wrStopped = wrStopped;
    st.rdLast    = (rdDone + ONE) == blkCountCfg;
    st.wrLast    = (wrDone + ONE) == blkCountCfg;
    st.loadLeft  = wrLoaded < blkCountCfg;
    st.bufWrRdy  = bufWrRdy;
  end

endmodule

// File: rtl/sd_xfer_status.sv
module sd_xfer_status
  import sd_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] blkCountCfg,
  input  logic             rdCmdEnd,
  input  logic             wrCmdEnd,
  input  logic             rdBlkToSys,
  input  logic             wrBufFull,
  input  logic             wrBlkTaken,
  input  logic             crcStatusRx,
  input  logic             stopAtGap,
  input  logic             contReq,
  output logic             bufWrRdy,
  output logic             rdActive,
  output logic             wrActive,
  output logic             irqBufWrRdy,
  output logic             irqXferDone,
  output logic             irqBlkGap
);

  xfer_strobe_t stb;
  xfer_state_t  st;

  sd_xfer_ctrl u_ctrl (
    .rdCmdEnd    (rdCmdEnd),
    .wrCmdEnd    (wrCmdEnd),
    .rdBlkToSys  (rdBlkToSys),
    .wrBufFull   (wrBufFull),
    .wrBlkTaken  (wrBlkTaken),
    .crcStatusRx (crcStatusRx),
    .stopAtGap   (stopAtGap),
    .contReq     (contReq),
    .st          (st),
    .stb         (stb)
  );

  sd_xfer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .blkCountCfg (blkCountCfg),
    .stb         (stb),
    .st          (st),
    .bufWrRdy    (bufWrRdy),
    .rdActive    (rdActive),
    .wrActive    (wrActive),
    .irqBufWrRdy (irqBufWrRdy),
    .irqXferDone (irqXferDone),
    .irqBlkGap   (irqBlkGap)
  );

endmodule

// File: rtl/sd_xfer_status_chk.sv
module sd_xfer_status_chk (
  input logic clk,
  input logic rstN,
  input logic rdCmdEnd,
  input logic wrCmdEnd,
  input logic rdBlkToSys,
  input logic wrBufFull,
  input logic crcStatusRx,
  input logic contReq,
  input logic bufWrRdy,
  input logic rdActive,
  input logic wrActive,
  input logic irqBufWrRdy,
  input logic irqXferDone,
  input logic irqBlkGap
);

  a_r2_rd_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdActive) |-> $past(rdCmdEnd || contReq));

  a_r3_rd_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdActive) |-> $past(rdBlkToSys));

  a_r5_done_low_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqXferDone |-> !rdActive);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    irqXferDone |=> !irqXferDone);

  a_r6_wr_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrActive) |-> $past(wrCmdEnd || contReq));

  a_r7_wr_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrActive) |-> $past(crcStatusRx));

  a_r8_gap_low_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqBlkGap |-> (!wrActive && $past(wrActive)));

  a_r9_bufirq_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqBufWrRdy |-> bufWrRdy);

  a_r9_bufirq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqBufWrRdy |=> !irqBufWrRdy);

  a_r10_full_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrBufFull && bufWrRdy) |=> !bufWrRdy);

endmodule

bind sd_xfer_status sd_xfer_status_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdCmdEnd    (rdCmdEnd),
  .wrCmdEnd    (wrCmdEnd),
  .rdBlkToSys  (rdBlkToSys),
  .wrBufFull   (wrBufFull),
  .crcStatusRx (crcStatusRx),
  .contReq     (contReq),
  .bufWrRdy    (bufWrRdy),
  .rdActive    (rdActive),
  .wrActive    (wrActive),
  .irqBufWrRdy (irqBufWrRdy),
  .irqXferDone (irqXferDone),
  .irqBlkGap   (irqBlkGap)
);

// File: tb/tb_sd_xfer_status.sv
module tb_sd_xfer_status;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] blkCountCfg = CNT_W'(1);
  logic rdCmdEnd = 0, wrCmdEnd = 0, rdBlkToSys = 0, wrBufFull = 0;
  logic wrBlkTaken = 0, crcStatusRx = 0, stopAtGap = 0, contReq = 0;
  logic bufWrRdy, rdActive, wrActive, irqBufWrRdy, irqXferDone, irqBlkGap;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sd_xfer_status #(.CNT_W(CNT_W)) dut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // 0 rdCmdEnd 1 wrCmdEnd 2 rdBlkToSys 3 wrBufFull 4 wrBlkTaken 5 crcStatusRx 6 contReq
  task automatic pulse(int which);
    case (which)
      0: rdCmdEnd = 1; 1: wrCmdEnd = 1; 2: rdBlkToSys = 1;
      3: wrBufFull = 1; 4: wrBlkTaken = 1; 5: crcStatusRx = 1;
      default: contReq = 1;
    endcase
    @(negedge clk);
    {rdCmdEnd, wrCmdEnd, rdBlkToSys, wrBufFull, wrBlkTaken, crcStatusRx, contReq} = '0;
  endtask

  // one read of n blocks, halting where stop bits say; model in bench
  task automatic run_read(int n, bit allowStop);
    int done = 0;
    blkCountCfg = CNT_W'(n);
    pulse(0);
    check("R2 rd start", rdActive, 1);
    while (done < n) begin
      bit stop = allowStop && ($urandom_range(0, 2) == 0);
      stopAtGap = stop;
      pulse(2);
      done++;
      if (done == n) begin
        check("R3 rd last clears", rdActive, 0);
        check("R5 done pulse", irqXferDone, 1);
      end else if (stop) begin
        check("R4 rd gap clears", rdActive, 0);
        check("R5 done pulse on gap", irqXferDone, 1);
        stopAtGap = 0;
        pulse(6);
        check("R2 rd continue", rdActive, 1);
        check("R5 no pulse", irqXferDone, 0);
      end else begin
        check("R3 rd still active", rdActive, 1);
        check("R5 no pulse mid", irqXferDone, 0);
      end
    end
    stopAtGap = 0;
    @(negedge clk);
    check("R5 pulse one cycle", irqXferDone, 0);
  endtask

  task automatic run_write(int n, bit allowStop);
    int loaded = 0;
    int done = 0;
    blkCountCfg = CNT_W'(n);
    pulse(1);
    check("R6 wr start", wrActive, 1);
    check("R9 buf ready start", bufWrRdy, 1);
    check("R9 buf irq start", irqBufWrRdy, 1);
    while (done < n) begin
      bit stop = allowStop && ($urandom_range(0, 2) == 0);
      pulse(3);
      loaded++;
      check("R10 full clears buf", bufWrRdy, 0);
      stopAtGap = stop;
      pulse(4);
      check("R10 taken sets buf", bufWrRdy, int'(loaded < n && !stop));
      check("R9 buf irq on rise", irqBufWrRdy, int'(loaded < n && !stop));
      pulse(5);
      done++;
      if (done == n) begin
        check("R7 wr last clears", wrActive, 0);
        check("R8 no gap irq at end", irqBlkGap, 0);
      end else if (stop) begin
        check("R8 wr gap clears", wrActive, 0);
        check("R8 gap irq", irqBlkGap, 1);
        stopAtGap = 0;
        @(negedge clk);
        check("R8 gap irq one cycle", irqBlkGap, 0);
        pulse(6);
        check("R6 wr continue", wrActive, 1);
        check("R11 continue refills buf", bufWrRdy, 1);
      end else begin
        check("R7 wr still active", wrActive, 1);
        check("R8 no gap irq mid", irqBlkGap, 0);
      end
    end
    stopAtGap = 0;
    check("R10 buf stays low after last", bufWrRdy, 0);
  endtask

  initial begin
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    check("R1 reset bufWrRdy", bufWrRdy, 0);
    check("R1 reset rdActive", rdActive, 0);
    check("R1 reset wrActive", wrActive, 0);
    check("R1 reset irqs", {irqBufWrRdy, irqXferDone, irqBlkGap}, 0);
    rstN = 1;
    @(negedge clk);

    // R11: continue with nothing halted
    pulse(6);
    check("R11 no flag change", {bufWrRdy, rdActive, wrActive}, 0);
    check("R11 no irq", {irqBufWrRdy, irqXferDone, irqBlkGap}, 0);

    // R12: stray strobes while idle, then exact length transfers
    pulse(2); pulse(2); pulse(5);
    check("R12 idle strobes no effect", {rdActive, wrActive}, 0);
    blkCountCfg = CNT_W'(2);
    pulse(0);
    pulse(2);
    check("R12 rd active after 1 of 2", rdActive, 1);
    pulse(2);
    check("R12 rd ends after 2", rdActive, 0);

    // directed: last block overrides gap request (read and write)
    blkCountCfg = CNT_W'(1);
    pulse(0);
    stopAtGap = 1;
    pulse(2);
    stopAtGap = 0;
    check("R3 last beats gap", rdActive, 0);
    pulse(6);
    check("R11 no resume after end", rdActive, 0);
    run_write(1, 0);

    for (int t = 0; t < 25; t++) begin
      run_read($urandom_range(1, 6), 1);
      run_write($urandom_range(1, 6), 1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule